// File: doc/BRIEF.md
# Double-Buffered Raster Pixel Reader

The block walks a frame of 16-bit pixels held in a word-addressed memory, issuing one read request per pixel, and delivers the returned words on a ready/valid stream in raster order. The stream carries a start marker on the first pixel and an end marker on the last one. Frames repeat without gaps for as long as the consumer keeps accepting pixels.

Two base addresses select where a frame lives in memory. The *front* base is the one being read. The *back* base is a spare that software may rewrite whenever it likes. Software asks for the two to trade places by writing the front register. The trade waits until the final pixel of the frame in progress has been requested. Until then a pending bit in the status word reads 1, so software can render into one buffer while the other is on screen and poll for the moment the new image is live.

A small register window also reports the frame size, the coordinate widths, the pixel size and the addressing mode. Read data is combinational on the register address.

Top module: `pixel_frame_reader`

## Requirements
- R1: Pixels leave in raster order: columns 0..H_RES-1 of row 0, then row 1, and so on to row V_RES-1. The next frame follows at once. Each 16-bit memory word (RGB565: red [15:11], green [10:5], blue [4:0]) is passed through unmodified.
- R2: Pixel (x, y) is read from word address front base + (y << X_BITS) + x. The column sits in bits X_BITS-1..0 and the row directly above it; with the defaults these are bits 8..0 and 16..9.
- R3: `px_sof` is high exactly on pixel (0,0) and `px_eof` exactly on pixel (H_RES-1, V_RES-1). The pixel that follows an end marker always carries a start marker.
- R4: While `px_valid` is high and `px_ready` is low, the next cycle keeps `px_valid` high with data and markers unchanged. No pixel is lost or repeated under any pattern of `px_ready` and `mem_gnt`.
- R5: Memory reads accepted, minus pixels accepted by the consumer, never exceed FIFO_DEPTH. Reads are accepted when `mem_req` and `mem_gnt` are both high, and responses return in order, one per cycle with `mem_rvalid`.
- R6: Register word offsets are: 0 front base, 1 back base, 2 size, 3 status. Reading offset 0 returns the front base. Any write to offset 0 requests a swap and its data is ignored. The size word holds V_RES in [31:16] and H_RES in [15:0].
- R7: The status word holds X_BITS in [31:24], Y_BITS in [23:16], the bytes per pixel (2) in [7:4], the addressing mode in bit 1 (0 = X-Y), and the pending flag S in bit 0. All other bits are zero.
- R8: After reset both bases equal DEFAULT_BASE, S is 0, and streaming begins at pixel (0,0) of the front base.
- R9: A swap request makes S read 1 from the next cycle. S stays 1, and the front base is unchanged, until the memory accepts the read for the last pixel of the current frame. On that edge the front and back bases exchange and S returns to 0, so the next frame is read from the former back base.
- R10: Further swap requests while S is 1 are absorbed: only one exchange happens, and later frames keep the new front base.
- R11: Writing offset 1 at any time changes only the back base. It leaves the front base and the pixel stream untouched.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 2 | Register word offset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | ADDR_W | Memory word address of the request |
| mem_gnt | input | 1 | Memory accepts the request this cycle |
| mem_rvalid | input | 1 | Read data valid, in request order |
| mem_rdata | input | PIX_W | Read data |
| px_valid | output | 1 | Pixel stream valid |
| px_ready | input | 1 | Pixel stream ready |
| px_data | output | PIX_W | Pixel word |
| px_sof | output | 1 | First pixel of a frame |
| px_eof | output | 1 | Last pixel of a frame |

## Verification
The hardest case to reach from the ports is a swap request that is still waiting. The request has to be seen pending across many cycles with the front base unchanged, and then seen to take effect exactly at a frame edge. To make the wait as long as needed, the stimulus first holds `px_ready` low until the read credits are used up, which freezes the read walk partway through a frame. It then writes the back base and the swap request, and only releases the stream afterwards. Once S drops, capture of the stream begins. The bench then checks that the pixel just before the first start marker is the old frame's final word and that the whole next frame comes from the new base. The same freeze is used to post several requests and show that only one exchange results.

// File: rtl/frame_reader_pkg.sv
// Package: register offsets and status-word packing shared by the frame reader.
// Assumes a 32-bit register window and 16-bit pixels (2 bytes each).
package frame_reader_pkg;

    typedef enum logic [1:0] {
        SEL_FRONT  = 2'd0,
        SEL_BACK   = 2'd1,
        SEL_SIZE   = 2'd2,
        SEL_STATUS = 2'd3
    } reg_sel_e;

    localparam int unsigned BYTES_PER_PIXEL = 2;
    localparam logic        ADDR_MODE_XY    = 1'b0;

    // Pack the status word from coordinate widths and the pending flag.
    function automatic logic [31:0] make_status(input int unsigned xb,
                                                input int unsigned yb,
                                                input logic pending);
        return {8'(xb), 8'(yb), 8'h00, 4'(BYTES_PER_PIXEL), 2'b00,
                ADDR_MODE_XY, pending};
    endfunction

endpackage

// File: rtl/fr_regs.sv
// Register window with the front/back base pair and the swap-pending flag.
// The exchange commits on the edge where the last pixel read of a frame is
// accepted (frame_fetched). A request arriving while one is already pending
// is absorbed. Assumes ADDR_W <= 32.
module fr_regs
    import frame_reader_pkg::*;
#(
    parameter int unsigned ADDR_W       = 32,
    parameter int unsigned H_RES        = 320,
    parameter int unsigned V_RES        = 240,
    parameter int unsigned X_BITS       = 9,
    parameter int unsigned Y_BITS       = 8,
    parameter logic [ADDR_W-1:0] DEFAULT_BASE = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        reg_addr,
    input  logic              reg_wr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              frame_fetched,
    output logic [ADDR_W-1:0] front_base,
    output logic              swap_pending
);

    localparam logic [31:0] SIZE_WORD = {16'(V_RES), 16'(H_RES)};

    logic [ADDR_W-1:0] back_base;
    logic              swap_wr;
    logic              back_wr;
    logic              commit;
    reg_sel_e          sel;

    assign sel     = reg_sel_e'(reg_addr);
    assign swap_wr = reg_wr && (sel == SEL_FRONT);
    assign back_wr = reg_wr && (sel == SEL_BACK);
    assign commit  = swap_pending && frame_fetched;

    // Base registers: software back writes, exchange at the frame edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            front_base <= DEFAULT_BASE;
            back_base  <= DEFAULT_BASE;
        end else if (commit) begin
            front_base <= back_base;
            back_base  <= front_base;
        end else if (back_wr) begin
            back_base  <= reg_wdata[ADDR_W-1:0];
        end
    end

    // Pending flag: set by a front write, cleared by the commit.
    always_ff @(posedge clk) begin
        if (!rst_n)       swap_pending <= 1'b0;
        else if (commit)  swap_pending <= 1'b0;
        else if (swap_wr) swap_pending <= 1'b1;
    end

    // Read mux, combinational on the register offset.
    always_comb begin
        unique case (sel)
            SEL_FRONT:  reg_rdata = 32'(front_base);
            SEL_BACK:   reg_rdata = 32'(back_base);
            SEL_SIZE:   reg_rdata = SIZE_WORD;
            SEL_STATUS: reg_rdata = make_status(X_BITS, Y_BITS, swap_pending);
            default:    reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/fr_fetch.sv
// Read-address walker. It steps (x, y) in raster order and issues one read
// per pixel while credits remain. A credit is taken on each accepted read and
// returned when the consumer accepts a pixel, so responses always find room
// in the FIFO. Assumes H_RES <= 2**X_BITS and V_RES <= 2**Y_BITS.
module fr_fetch #(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned H_RES      = 320,
    parameter int unsigned V_RES      = 240,
    parameter int unsigned X_BITS     = 9,
    parameter int unsigned Y_BITS     = 8,
    parameter int unsigned FIFO_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] front_base,
    input  logic              mem_gnt,
    input  logic              px_taken,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              frame_fetched
);

    localparam int unsigned CRD_W = $clog2(FIFO_DEPTH + 1);
    localparam logic [X_BITS-1:0] X_LAST = X_BITS'(H_RES - 1);
    localparam logic [Y_BITS-1:0] Y_LAST = Y_BITS'(V_RES - 1);
    localparam logic [CRD_W-1:0]  CRD_MAX = CRD_W'(FIFO_DEPTH);

    logic [X_BITS-1:0] fx;
    logic [Y_BITS-1:0] fy;
    logic [CRD_W-1:0]  credits_used;
    logic              issue;
    logic              row_end;

    assign mem_req       = (credits_used < CRD_MAX);
    assign issue         = mem_req && mem_gnt;
    assign row_end       = (fx == X_LAST);
    assign frame_fetched = issue && row_end && (fy == Y_LAST);
    assign mem_addr      = front_base + ADDR_W'({fy, fx});

    // Raster position of the next read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fx <= '0;
            fy <= '0;
        end else if (issue) begin
            if (row_end) begin
                fx <= '0;
                fy <= (fy == Y_LAST) ? '0 : fy + 1'b1;
            end else begin
                fx <= fx + 1'b1;
            end
        end
    end

    // Credit count: reads accepted but not yet consumed downstream.
    always_ff @(posedge clk) begin
        if (!rst_n) credits_used <= '0;
        else        credits_used <= credits_used + CRD_W'(issue) - CRD_W'(px_taken);
    end

endmodule

// File: rtl/fr_fifo.sv
// Synchronous FIFO for read responses. The depth need not be a power of two.
// The caller guarantees no push when full and no pop when empty.
module fr_fifo #(
    parameter int unsigned WIDTH = 16,
    parameter int unsigned DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic             empty,
    output logic             full
);

    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

    logic [WIDTH-1:0] store [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [CNT_W-1:0] count;

    assign empty = (count == '0);
    assign full  = (count == CNT_W'(DEPTH));
    assign rdata = store[rd_ptr];

    // Storage write, no reset needed on data.
    always_ff @(posedge clk) begin
        if (push) store[wr_ptr] <= wdata;
    end

    // Pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= (wr_ptr == PTR_LAST) ? '0 : wr_ptr + 1'b1;
            if (pop)  rd_ptr <= (rd_ptr == PTR_LAST) ? '0 : rd_ptr + 1'b1;
            count <= count + CNT_W'(push) - CNT_W'(pop);
        end
    end

endmodule

// File: rtl/fr_position.sv
// Output-side raster position. It advances on each accepted pixel and
// derives the frame markers. It stays aligned with the read walker because
// responses return in order, one per read.
module fr_position #(
    parameter int unsigned H_RES  = 320,
    parameter int unsigned V_RES  = 240,
    parameter int unsigned X_BITS = 9,
    parameter int unsigned Y_BITS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic advance,
    output logic at_first,
    output logic at_last
);

    localparam logic [X_BITS-1:0] X_LAST = X_BITS'(H_RES - 1);
    localparam logic [Y_BITS-1:0] Y_LAST = Y_BITS'(V_RES - 1);

    logic [X_BITS-1:0] ox;
    logic [Y_BITS-1:0] oy;

    assign at_first = (ox == '0) && (oy == '0);
    assign at_last  = (ox == X_LAST) && (oy == Y_LAST);

    // Position of the pixel currently at the stream head.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ox <= '0;
            oy <= '0;
        end else if (advance) begin
            if (ox == X_LAST) begin
                ox <= '0;
                oy <= (oy == Y_LAST) ? '0 : oy + 1'b1;
            end else begin
                ox <= ox + 1'b1;
            end
        end
    end

endmodule

// File: rtl/pixel_frame_reader.sv
// Top level: a double-buffered raster reader. It ties together the register
// window, the read walker, the response FIFO and the output position
// counter. Memory responses must return in request order.
module pixel_frame_reader #(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned PIX_W      = 16,
    parameter int unsigned H_RES      = 320,
    parameter int unsigned V_RES      = 240,
    parameter int unsigned X_BITS     = 9,
    parameter int unsigned Y_BITS     = 8,
    parameter int unsigned FIFO_DEPTH = 4,
    parameter logic [ADDR_W-1:0] DEFAULT_BASE = ADDR_W'(32'h0800_0000)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        reg_addr,
    input  logic              reg_wr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_gnt,
    input  logic              mem_rvalid,
    input  logic [PIX_W-1:0]  mem_rdata,
    output logic              px_valid,
    input  logic              px_ready,
    output logic [PIX_W-1:0]  px_data,
    output logic              px_sof,
    output logic              px_eof
);

    logic [ADDR_W-1:0] front_base;
    logic              swap_pending;
    logic              frame_fetched;
    logic              px_taken;
    logic              fifo_empty;
    logic              fifo_full;
    logic              at_first;
    logic              at_last;

    assign px_valid = !fifo_empty;
    assign px_taken = px_valid && px_ready;
    assign px_sof   = px_valid && at_first;
    assign px_eof   = px_valid && at_last;

    fr_regs #(
        .ADDR_W(ADDR_W), .H_RES(H_RES), .V_RES(V_RES),
        .X_BITS(X_BITS), .Y_BITS(Y_BITS), .DEFAULT_BASE(DEFAULT_BASE)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .frame_fetched(frame_fetched),
        .front_base(front_base), .swap_pending(swap_pending)
    );

    fr_fetch #(
        .ADDR_W(ADDR_W), .H_RES(H_RES), .V_RES(V_RES),
        .X_BITS(X_BITS), .Y_BITS(Y_BITS), .FIFO_DEPTH(FIFO_DEPTH)
    ) u_fetch (
        .clk(clk), .rst_n(rst_n), .front_base(front_base),
        .mem_gnt(mem_gnt), .px_taken(px_taken),
        .mem_req(mem_req), .mem_addr(mem_addr),
        .frame_fetched(frame_fetched)
    );

    fr_fifo #(
        .WIDTH(PIX_W), .DEPTH(FIFO_DEPTH)
    ) u_fifo (
        .clk(clk), .rst_n(rst_n),
        .push(mem_rvalid), .wdata(mem_rdata),
        .pop(px_taken), .rdata(px_data),
        .empty(fifo_empty), .full(fifo_full)
    );

    fr_position #(
        .H_RES(H_RES), .V_RES(V_RES), .X_BITS(X_BITS), .Y_BITS(Y_BITS)
    ) u_pos (
        .clk(clk), .rst_n(rst_n), .advance(px_taken),
        .at_first(at_first), .at_last(at_last)
    );

endmodule

// File: rtl/frame_reader_checker.sv
// Checker for pixel_frame_reader, attached by bind. It observes the stream,
// the memory request side and the base/pending state, and keeps its own
// credit and frame-edge trackers.
module frame_reader_checker #(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned PIX_W      = 16,
    parameter int unsigned FIFO_DEPTH = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_req,
    input logic              mem_gnt,
    input logic              px_valid,
    input logic              px_ready,
    input logic [PIX_W-1:0]  px_data,
    input logic              px_sof,
    input logic              px_eof,
    input logic [ADDR_W-1:0] front_base,
    input logic              swap_pending
);

    int   held;
    logic expect_sof;

    // Reads accepted minus pixels consumed.
    always_ff @(posedge clk) begin
        if (!rst_n) held <= 0;
        else        held <= held + int'(mem_req && mem_gnt) - int'(px_valid && px_ready);
    end

    // Set after an accepted end marker; the next pixel must start a frame.
    always_ff @(posedge clk) begin
        if (!rst_n)                     expect_sof <= 1'b1;
        else if (px_valid && px_ready)  expect_sof <= px_eof;
    end

    assert_hold_while_stalled_R4: assert property (@(posedge clk) disable iff (!rst_n)
        px_valid && !px_ready |=> px_valid && $stable(px_data) && $stable(px_sof) && $stable(px_eof));

    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        held <= int'(FIFO_DEPTH));

    assert_markers_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(px_sof && px_eof));

    assert_start_after_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
        px_valid && expect_sof |-> px_sof);

    assert_front_moves_only_when_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(front_base) |-> $past(swap_pending));

    assert_exchange_on_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(swap_pending) |-> !$stable(front_base));

    assert_single_exchange_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(front_base) |=> $stable(front_base) && !swap_pending);

endmodule

bind pixel_frame_reader frame_reader_checker #(
    .ADDR_W(ADDR_W), .PIX_W(PIX_W), .FIFO_DEPTH(FIFO_DEPTH)
) u_checker (
    .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_gnt(mem_gnt),
    .px_valid(px_valid), .px_ready(px_ready), .px_data(px_data),
    .px_sof(px_sof), .px_eof(px_eof),
    .front_base(front_base), .swap_pending(swap_pending)
);

// File: tb/pixel_frame_reader_bench.sv
// Directed bench for pixel_frame_reader with a small 10x6 frame. Memory is a
// two-cycle in-order responder whose word at address a is computed by pix_of.
module pixel_frame_reader_bench;

    localparam int unsigned HR = 10;
    localparam int unsigned VR = 6;
    localparam int unsigned XB = 4;
    localparam int unsigned YB = 3;
    localparam int unsigned DEPTH = 4;
    localparam int unsigned NPIX = HR * VR;
    localparam logic [31:0] DEF_BASE = 32'h0000_0100;
    localparam logic [31:0] BASE_B   = 32'h0000_0200;
    localparam logic [31:0] BASE_C   = 32'h0000_0300;
    localparam int CAP_MAX = 2048;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_gnt = 1'b1;
    logic        mem_rvalid;
    logic [15:0] mem_rdata;
    logic        px_valid;
    logic        px_ready = 1'b0;
    logic [15:0] px_data;
    logic        px_sof;
    logic        px_eof;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    pixel_frame_reader #(
        .ADDR_W(32), .PIX_W(16), .H_RES(HR), .V_RES(VR),
        .X_BITS(XB), .Y_BITS(YB), .FIFO_DEPTH(DEPTH), .DEFAULT_BASE(DEF_BASE)
    ) u_pixel_frame_reader (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata), .px_valid(px_valid), .px_ready(px_ready),
        .px_data(px_data), .px_sof(px_sof), .px_eof(px_eof)
    );

    function automatic logic [15:0] pix_of(input logic [31:0] a);
        logic [31:0] t;
        t = (a * 32'd40503) ^ 32'h0000_5A5A;
        return t[15:0];
    endfunction

    // Memory model: two-cycle in-order response.
    logic        p0_v, p1_v;
    logic [31:0] p0_a, p1_a;
    always @(posedge clk) begin
        if (!rst_n) begin
            p0_v <= 1'b0; p1_v <= 1'b0; p0_a <= '0; p1_a <= '0;
        end else begin
            p0_v <= mem_req && mem_gnt; p0_a <= mem_addr;
            p1_v <= p0_v;               p1_a <= p0_a;
        end
    end
    assign mem_rvalid = p1_v;
    assign mem_rdata  = pix_of(p1_a);

    // Random ready/grant driver used in the back-pressure scenario.
    bit          rand_mode = 1'b0;
    logic [15:0] lfsr = 16'hACE1;
    always begin
        @(posedge clk);
        #2;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        if (rand_mode) begin
            px_ready = lfsr[0] | lfsr[3];
            mem_gnt  = lfsr[5] | lfsr[9];
        end
    end

    // Stream capture at the falling edge.
    bit          cap_on = 1'b0;
    int          cap_n = 0;
    logic [15:0] cap_d [CAP_MAX];
    logic        cap_s [CAP_MAX];
    logic        cap_e [CAP_MAX];
    always @(negedge clk) begin
        if (cap_on && px_valid && px_ready && cap_n < CAP_MAX) begin
            cap_d[cap_n] = px_data;
            cap_s[cap_n] = px_sof;
            cap_e[cap_n] = px_eof;
            cap_n = cap_n + 1;
        end
    end

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    task automatic read_reg(input logic [1:0] sel, output logic [31:0] val);
        step();
        reg_addr = sel;
        @(negedge clk);
        val = reg_rdata;
    endtask

    task automatic write_reg(input logic [1:0] sel, input logic [31:0] val);
        step();
        reg_addr = sel; reg_wdata = val; reg_wr = 1'b1;
        step();
        reg_wr = 1'b0;
    endtask

    task automatic start_capture();
        cap_n = 0;
        cap_on = 1'b1;
    endtask

    task automatic wait_cap(input int n);
        for (int i = 0; i < 20000 && cap_n < n; i++) step();
    endtask

    function automatic int first_sof();
        for (int i = 0; i < cap_n; i++) if (cap_s[i]) return i;
        return -1;
    endfunction

    // Compare one whole frame of the capture, starting at index s, with a base.
    task automatic verify_frame(input int s, input logic [31:0] base, input string req);
        int bad_d = 0;
        int bad_m = 0;
        logic [31:0] first_act = '0;
        logic [31:0] first_exp = '0;
        for (int k = 0; k < int'(NPIX); k++) begin
            int x = k % int'(HR);
            int y = k / int'(HR);
            logic [15:0] e = pix_of(base + 32'(y << XB) + 32'(x));
            if (s < 0 || s + k >= cap_n) begin
                bad_d++;
            end else begin
                if (cap_d[s+k] !== e) begin
                    if (bad_d == 0) begin first_act = 32'(cap_d[s+k]); first_exp = 32'(e); end
                    bad_d++;
                end
                if (cap_s[s+k] !== (k == 0) || cap_e[s+k] !== (k == int'(NPIX) - 1)) bad_m++;
            end
        end
        chk(bad_d == 0, req, "frame pixel data (R1 R2)", first_act, first_exp);
        chk(bad_m == 0, req, "frame markers (R3)", 32'(bad_m), 32'd0);
    endtask

    // Wait for S to clear, then start capture one cycle later.
    task automatic wait_swap_and_capture(output bit cleared);
        logic [31:0] v;
        cleared = 1'b0;
        for (int i = 0; i < 2000; i++) begin
            read_reg(2'd3, v);
            if (v[0] == 1'b0) begin cleared = 1'b1; break; end
        end
        step();
        start_capture();
    endtask

    task automatic t_reset();
        logic [31:0] v;
        logic [15:0] d0;
        read_reg(2'd0, v); chk(v == DEF_BASE, "R8", "front after reset", v, DEF_BASE);
        read_reg(2'd1, v); chk(v == DEF_BASE, "R8", "back after reset", v, DEF_BASE);
        read_reg(2'd2, v); chk(v == 32'h0006_000A, "R6", "size word", v, 32'h0006_000A);
        read_reg(2'd3, v); chk(v == 32'h0403_0020, "R7", "status word", v, 32'h0403_0020);
        repeat (10) step();
        @(negedge clk);
        chk(px_valid && px_sof && px_data == pix_of(DEF_BASE), "R8", "first pixel (0,0) waiting",
            32'(px_data), 32'(pix_of(DEF_BASE)));
        d0 = px_data;
        repeat (5) step();
        @(negedge clk);
        chk(px_valid && px_data == d0 && px_sof, "R4", "stalled head held", 32'(px_data), 32'(d0));
    endtask

    task automatic t_raster();
        step();
        start_capture();
        px_ready = 1'b1;
        wait_cap(2 * NPIX);
        verify_frame(0, DEF_BASE, "R1");
        verify_frame(NPIX, DEF_BASE, "R3");
        cap_on = 1'b0;
    endtask

    task automatic t_pending_swap();
        logic [31:0] v;
        bit cl;
        int s;
        step(); px_ready = 1'b0;
        repeat (12) step();
        write_reg(2'd1, BASE_B);
        read_reg(2'd1, v); chk(v == BASE_B, "R11", "back readback", v, BASE_B);
        read_reg(2'd0, v); chk(v == DEF_BASE, "R11", "front unchanged by back write", v, DEF_BASE);
        write_reg(2'd0, 32'hDEAD_BEEF);
        read_reg(2'd3, v); chk(v[0] == 1'b1, "R9", "S set after request", v, 32'h0403_0021);
        repeat (30) step();
        read_reg(2'd3, v); chk(v[0] == 1'b1, "R9", "S held while frame open", v, 32'h0403_0021);
        read_reg(2'd0, v); chk(v == DEF_BASE, "R9", "front held while pending", v, DEF_BASE);
        step(); px_ready = 1'b1;
        wait_swap_and_capture(cl);
        chk(cl, "R9", "S cleared", 32'(cl), 32'd1);
        read_reg(2'd0, v); chk(v == BASE_B, "R6", "front after swap, write data ignored", v, BASE_B);
        read_reg(2'd1, v); chk(v == DEF_BASE, "R9", "back after swap", v, DEF_BASE);
        wait_cap(3 * NPIX);
        s = first_sof();
        chk(s >= 1 && cap_e[s-1] && cap_d[s-1] == pix_of(DEF_BASE + 32'((VR-1) << XB) + 32'(HR-1)),
            "R9", "old frame ends before new start", 32'(s), 32'd1);
        verify_frame(s, BASE_B, "R9");
        verify_frame(s + NPIX, BASE_B, "R9");
        cap_on = 1'b0;
    endtask

    task automatic t_absorb();
        logic [31:0] v;
        bit cl;
        int s;
        step(); px_ready = 1'b0;
        repeat (12) step();
        write_reg(2'd1, BASE_C);
        write_reg(2'd0, 32'h0);
        write_reg(2'd0, 32'h1);
        write_reg(2'd0, 32'h2);
        read_reg(2'd3, v); chk(v[0] == 1'b1, "R10", "S set after repeated requests", v, 32'h0403_0021);
        step(); px_ready = 1'b1;
        wait_swap_and_capture(cl);
        chk(cl, "R10", "S cleared", 32'(cl), 32'd1);
        read_reg(2'd0, v); chk(v == BASE_C, "R10", "front after one exchange", v, BASE_C);
        read_reg(2'd1, v); chk(v == BASE_B, "R10", "back after one exchange", v, BASE_B);
        wait_cap(4 * NPIX);
        s = first_sof();
        verify_frame(s, BASE_C, "R10");
        verify_frame(s + 2 * NPIX, BASE_C, "R10");
        read_reg(2'd0, v); chk(v == BASE_C, "R10", "no second exchange", v, BASE_C);
        read_reg(2'd3, v); chk(v[0] == 1'b0, "R10", "S stays clear", v, 32'h0403_0020);
        cap_on = 1'b0;
    endtask

    task automatic t_backpressure();
        int s;
        step();
        start_capture();
        rand_mode = 1'b1;
        wait_cap(4 * NPIX);
        rand_mode = 1'b0;
        step(); px_ready = 1'b1; mem_gnt = 1'b1;
        cap_on = 1'b0;
        s = first_sof();
        verify_frame(s, BASE_C, "R4");
        verify_frame(s + NPIX, BASE_C, "R5");
        verify_frame(s + 2 * NPIX, BASE_C, "R4");
    endtask

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (5) @(posedge clk);
        #2 rst_n = 1'b1;
        t_reset();
        t_raster();
        t_pending_swap();
        t_absorb();
        t_backpressure();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule